// File: doc/BRIEF.md
# Adaptor Identification Register Target

This block is a target on a two-wire serial bus. It answers a single fixed target address and serves a 256-location byte register space that identifies a video-port adaptor to the host. A write transaction loads a byte pointer. Later reads return bytes from that pointer. The pointer advances by one after every data byte and wraps from FFh to 00h.

Most locations hold constant identification data. A mode input selects between an HDMI content profile and a DVI content profile. One location reflects a single control input bit. Four locations can be written. Three of them drive output ports: an output-driver disable bit, a CEC connection enable bit and a bus-speed code. The speed location checks each written value and stores its default when the value is not legal.

The clock and data lines are synchronized and glitch-filtered on the system clock. The block drives data only as an open-drain pull-down request. A select pin gates whether the block responds at all.

Top module: `adaptor_id_target`

## Requirements
- R1: The block acknowledges the address byte 80h (7-bit 40h, write) or 81h (read) only while `sel_ni` is low. Any other address, or any address while `sel_ni` is high, gets no acknowledge (SDA left released).
- R2: The first data byte of a write transaction loads the byte pointer. Later data bytes of the same transaction are written at the pointer.
- R3: With `hdmi_mode_i`=1, locations 00h–0Eh read as the ASCII text "DP-HDMI ADAPTOR" (00h = 44h, 02h = 2Dh, 0Eh = 52h) and 0Fh reads 04h. With `hdmi_mode_i`=0, locations 00h–0Fh read 00h.
- R4: Location 10h reads A0h in HDMI mode and 00h in DVI mode.
- R5: Locations 11h–13h read 08h, 00h, 28h. Locations 14h–19h read the bytes of parameter DEV_ID, most significant byte first. 1Ah reads 02h. 1Bh–1Ch read 00h.
- R6: Location 1Dh reads F0h in HDMI mode and 42h in DVI mode. 1Eh reads 0Fh when `rate_sel_i`=0 and 1Fh when it is 1.
- R7: Location 20h resets to 00h. Its bit 0 is writable and drives `tmds_dis_o`. Bits 7:1 read 0. Location 21h behaves the same way, with bit 0 driving `cec_en_o`.
- R8: Location 22h resets to 08h. A write of 01h, 02h, 04h, 08h or 10h is stored. Any other written value stores 08h. Reads and `speed_code_o` show the stored code.
- R9: Location 1Fh is a full read/write byte that resets to 00h. Locations 23h–FFh read 00h. Writes to read-only locations are acknowledged and change nothing.
- R10: The pointer increments after each data byte read or written and wraps from FFh to 00h.
- R11: A START at any point restarts the address phase. A STOP returns the block to idle. A master NACK on a read byte ends the data transfer with SDA released.
- R12: After reset, `tmds_dis_o`=0, `cec_en_o`=0, `speed_code_o`=08h and `sda_low_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_low_o | output | 1 | Pull SDA low when 1 (open-drain request) |
| sel_ni | input | 1 | Select, block responds only when low |
| hdmi_mode_i | input | 1 | 1 = HDMI content profile, 0 = DVI profile |
| rate_sel_i | input | 1 | Control bit reflected in location 1Eh |
| tmds_dis_o | output | 1 | Output-driver disable, location 20h bit 0 |
| cec_en_o | output | 1 | CEC connection enable, location 21h bit 0 |
| speed_code_o | output | 8 | Stored bus-speed code, location 22h |

## Verification
The assertions assume that SDA changes only while SCL is low, except for START and STOP. They also assume that every line level is held longer than the glitch filter window, so that filtered edges match the bus protocol. The bench master keeps SCL high and low for at least twelve system clocks per quarter bit. It moves SDA only in the middle of the SCL-low phase, except when it deliberately forms START and STOP. The select pin and the mode inputs are changed only between transactions.

// File: rtl/aid_pkg.sv
package aid_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } bus_state_e;

  localparam logic [7:0] SPEED_DEFAULT = 8'h08;

  function automatic logic speed_legal(input logic [7:0] v);
    return (v[7:5] == 3'b000) && ($countones(v) == 1);
  endfunction
endpackage

// File: rtl/aid_line_filter.sv
module aid_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          line_o <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/aid_bus_fsm.sv
module aid_bus_fsm
  import aid_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       sel_ni,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       sda_low_o
);
  bus_state_e state_q;
  logic       scl_q, sda_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q;
  logic       rw_q, first_q, nack_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  scl_i & ~scl_q;
  assign scl_fall  = ~scl_i &  scl_q;
  assign start_det =  scl_i &  scl_q & sda_q & ~sda_i;
  assign stop_det  =  scl_i &  scl_q & ~sda_q & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      ptr_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      sda_low_o <= 1'b0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        first_q   <= 1'b1;
        sda_low_o <= 1'b0;
      end else if (stop_det) begin
        state_q   <= ST_IDLE;
        sda_low_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (sh_q[7:1] == TGT_ADDR && !sel_ni) begin
                sda_low_o <= 1'b1;
                rw_q      <= sh_q[0];
                state_q   <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q      <= rd_data_i;
              sda_low_o <= ~rd_data_i[7];
              state_q   <= ST_RDATA;
            end else begin
              sda_low_o <= 1'b0;
              state_q   <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              sda_low_o <= 1'b1;
              state_q   <= ST_WACK;
              if (first_q) begin
                ptr_o   <= sh_q;
                first_q <= 1'b0;
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_o;
                wr_data_o <= sh_q;
                ptr_o     <= ptr_o + 8'd1;
              end
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_low_o <= 1'b0;
            cnt_q     <= '0;
            state_q   <= ST_WDATA;
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_low_o <= 1'b0;
                ptr_o     <= ptr_o + 8'd1;
                state_q   <= ST_RACK;
              end else if (cnt_q != 4'd0) begin
                tx_q      <= {tx_q[6:0], 1'b0};
                sda_low_o <= ~tx_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_i;
            end else if (scl_fall) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                tx_q      <= rd_data_i;
                sda_low_o <= ~rd_data_i[7];
                cnt_q     <= '0;
                state_q   <= ST_RDATA;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: START restarts address phase, STOP idles
  a_r11_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state_q == ST_ADDR);
  a_r11_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !sda_low_o));
  // R1: no acknowledge while deselected
  a_r1_no_ack_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && scl_fall && cnt_q == 4'd8 && sel_ni && !start_det && !stop_det)
      |=> !sda_low_o);
  // R10: pointer steps by one after each byte read
  a_r10_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDATA && scl_fall && cnt_q == 4'd8) |=> ptr_o == $past(ptr_o) + 8'd1);
  // R11: idle never drives the line
  a_r11_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_low_o);
endmodule

// File: rtl/aid_reg_space.sv
module aid_reg_space
  import aid_pkg::*;
#(
  parameter logic [47:0] DEV_ID = 48'h41_49_44_30_31_00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] rd_addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       hdmi_mode_i,
  input  logic       rate_sel_i,
  output logic [7:0] rd_data_o,
  output logic       tmds_dis_o,
  output logic       cec_en_o,
  output logic [7:0] speed_code_o
);
  localparam int          TXT_LEN = 15;
  localparam logic [8*TXT_LEN-1:0] ID_TEXT = "DP-HDMI ADAPTOR";
  localparam int          DEV_LEN = 6;

  logic [7:0] scratch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q    <= '0;
      tmds_dis_o   <= 1'b0;
      cec_en_o     <= 1'b0;
      speed_code_o <= SPEED_DEFAULT;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        8'h1F: scratch_q  <= wr_data_i;
        8'h20: tmds_dis_o <= wr_data_i[0];
        8'h21: cec_en_o   <= wr_data_i[0];
        8'h22: speed_code_o <= speed_legal(wr_data_i) ? wr_data_i : SPEED_DEFAULT;
        default: ;
      endcase
    end
  end

  always_comb begin
    int idx;
    idx       = 0;
    rd_data_o = 8'h00;
    if (rd_addr_i < 8'(TXT_LEN)) begin
      idx       = TXT_LEN - 1 - int'(rd_addr_i);
      rd_data_o = hdmi_mode_i ? ID_TEXT[idx*8 +: 8] : 8'h00;
    end else if (rd_addr_i >= 8'h14 && rd_addr_i < 8'(8'h14 + DEV_LEN)) begin
      idx       = DEV_LEN - 1 - int'(rd_addr_i - 8'h14);
      rd_data_o = DEV_ID[idx*8 +: 8];
    end else begin
      unique case (rd_addr_i)
        8'h0F: rd_data_o = hdmi_mode_i ? 8'h04 : 8'h00;
        8'h10: rd_data_o = hdmi_mode_i ? 8'hA0 : 8'h00;
        8'h11: rd_data_o = 8'h08;
        8'h13: rd_data_o = 8'h28;
        8'h1A: rd_data_o = 8'h02;
        8'h1D: rd_data_o = hdmi_mode_i ? 8'hF0 : 8'h42;
        8'h1E: rd_data_o = rate_sel_i ? 8'h1F : 8'h0F;
        8'h1F: rd_data_o = scratch_q;
        8'h20: rd_data_o = {7'b0, tmds_dis_o};
        8'h21: rd_data_o = {7'b0, cec_en_o};
        8'h22: rd_data_o = speed_code_o;
        default: rd_data_o = 8'h00;
      endcase
    end
  end

  // R8: stored speed code is always one of the legal codes
  a_r8_speed_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_legal(speed_code_o));
  // R8: an illegal write lands on the default code
  a_r8_illegal_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 8'h22 && !speed_legal(wr_data_i)) |=> speed_code_o == SPEED_DEFAULT);
  // R9: writes elsewhere leave the writable bytes alone
  a_r9_ro_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i < 8'h1F || wr_addr_i > 8'h22)) |=>
      $stable(scratch_q) && $stable(speed_code_o) && $stable(tmds_dis_o) && $stable(cec_en_o));
endmodule

// File: rtl/adaptor_id_target.sv
module adaptor_id_target #(
  parameter logic [6:0]  TGT_ADDR = 7'h40,
  parameter logic [47:0] DEV_ID   = 48'h41_49_44_30_31_00,
  parameter int          FILT_LEN = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_low_o,
  input  logic       sel_ni,
  input  logic       hdmi_mode_i,
  input  logic       rate_sel_i,
  output logic       tmds_dis_o,
  output logic       cec_en_o,
  output logic [7:0] speed_code_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    aid_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  logic [7:0] ptr, rd_data, wr_addr, wr_data;
  logic       wr_en;

  aid_bus_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (filt[0]),
    .sda_i    (filt[1]),
    .sel_ni   (sel_ni),
    .rd_data_i(rd_data),
    .ptr_o    (ptr),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sda_low_o(sda_low_o)
  );

  aid_reg_space #(.DEV_ID(DEV_ID)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   (ptr),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .hdmi_mode_i (hdmi_mode_i),
    .rate_sel_i  (rate_sel_i),
    .rd_data_o   (rd_data),
    .tmds_dis_o  (tmds_dis_o),
    .cec_en_o    (cec_en_o),
    .speed_code_o(speed_code_o)
  );
endmodule

// File: tb/tb_adaptor_id_target.sv
module tb_adaptor_id_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sel_n = 1'b0, hdmi = 1'b1, rate = 1'b0;
  logic sda_low, tmds_dis, cec_en;
  logic [7:0] speed;
  wire  sda_bus = sda_m & ~sda_low;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  adaptor_id_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_low_o(sda_low), .sel_ni(sel_n), .hdmi_mode_i(hdmi),
    .rate_sel_i(rate), .tmds_dis_o(tmds_dis), .cec_en_o(cec_en),
    .speed_code_o(speed)
  );

  // {hdmi, rate, addr, expected}
  localparam int NV = 22;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00, 8'h44},  // R3
    {1'b1, 1'b0, 8'h02, 8'h2D},  // R3
    {1'b1, 1'b0, 8'h0E, 8'h52},  // R3
    {1'b1, 1'b0, 8'h0F, 8'h04},  // R3
    {1'b0, 1'b0, 8'h05, 8'h00},  // R3
    {1'b0, 1'b0, 8'h0F, 8'h00},  // R3
    {1'b1, 1'b0, 8'h10, 8'hA0},  // R4
    {1'b0, 1'b0, 8'h10, 8'h00},  // R4
    {1'b1, 1'b0, 8'h11, 8'h08},  // R5
    {1'b0, 1'b0, 8'h12, 8'h00},  // R5
    {1'b1, 1'b0, 8'h13, 8'h28},  // R5
    {1'b1, 1'b0, 8'h14, 8'h41},  // R5
    {1'b0, 1'b0, 8'h18, 8'h31},  // R5
    {1'b1, 1'b0, 8'h1A, 8'h02},  // R5
    {1'b1, 1'b0, 8'h1C, 8'h00},  // R5
    {1'b1, 1'b0, 8'h1D, 8'hF0},  // R6
    {1'b0, 1'b0, 8'h1D, 8'h42},  // R6
    {1'b1, 1'b0, 8'h1E, 8'h0F},  // R6
    {1'b1, 1'b1, 8'h1E, 8'h1F},  // R6
    {1'b1, 1'b0, 8'h23, 8'h00},  // R9
    {1'b1, 1'b0, 8'hC7, 8'h00},  // R9
    {1'b1, 1'b0, 8'h22, 8'h08}   // R8, R12
  };

  task automatic q();
    repeat (12) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(last);
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic ack;
    bus_start(); wr_byte(8'h80, ack); wr_byte(a, ack); bus_stop();
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    logic ack;
    bus_start(); wr_byte(8'h80, ack); wr_byte(a, ack); wr_byte(d, ack); bus_stop();
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    logic ack;
    set_ptr(a);
    bus_start(); wr_byte(8'h81, ack); rd_byte(d, 1'b1); bus_stop();
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    check("R12 speed", speed, 8'h08);
    check("R12 tmds", {7'b0, tmds_dis}, 8'h00);
    check("R12 cec", {7'b0, cec_en}, 8'h00);
    check("R12 sda", {7'b0, sda_low}, 8'h00);

    // vector table: R3 R4 R5 R6 R8 R9, pointer set by write (R2)
    for (int v = 0; v < NV; v++) begin
      hdmi = VEC[v][17];
      rate = VEC[v][16];
      rd_reg(VEC[v][15:8], d);
      check($sformatf("R2/R3-R6 table %0d", v), d, VEC[v][7:0]);
    end
    hdmi = 1'b1; rate = 1'b0;

    // R1: address match and select
    bus_start(); wr_byte(8'h80, ack); bus_stop();
    check("R1 ack 80h", {7'b0, ack}, 8'h01);
    bus_start(); wr_byte(8'h90, ack); bus_stop();
    check("R1 wrong address", {7'b0, ack}, 8'h00);
    sel_n = 1'b1;
    bus_start(); wr_byte(8'h81, ack); bus_stop();
    check("R1 deselected", {7'b0, ack}, 8'h00);
    sel_n = 1'b0;

    // R2 R10: burst write 1Fh..21h
    bus_start(); wr_byte(8'h80, ack); wr_byte(8'h1F, ack);
    wr_byte(8'hA5, ack); wr_byte(8'hFF, ack); wr_byte(8'h01, ack); bus_stop();
    check("R9 ack data", {7'b0, ack}, 8'h01);
    check("R7 tmds_dis", {7'b0, tmds_dis}, 8'h01);
    check("R7 cec_en", {7'b0, cec_en}, 8'h01);
    rd_reg(8'h1F, d); check("R9 scratch", d, 8'hA5);
    rd_reg(8'h20, d); check("R7 reserved bits", d, 8'h01);
    wr_reg(8'h20, 8'h00);
    check("R7 tmds clear", {7'b0, tmds_dis}, 8'h00);

    // R8: speed validation
    wr_reg(8'h22, 8'h10); check("R8 legal 10h", speed, 8'h10);
    rd_reg(8'h22, d); check("R8 read back", d, 8'h10);
    wr_reg(8'h22, 8'h03); check("R8 illegal 03h", speed, 8'h08);
    wr_reg(8'h22, 8'h01); check("R8 legal 01h", speed, 8'h01);
    wr_reg(8'h22, 8'h20); check("R8 illegal 20h", speed, 8'h08);

    // R9: read-only write ignored
    wr_reg(8'h11, 8'h55);
    rd_reg(8'h11, d); check("R9 ro ignored", d, 8'h08);

    // R10: multi-byte read and wrap
    set_ptr(8'hFF);
    bus_start(); wr_byte(8'h81, ack); rd_byte(d, 1'b0); rd_byte(d2, 1'b1);
    check("R11 nack release", {7'b0, sda_low}, 8'h00);
    bus_stop();
    check("R10 byte FFh", d, 8'h00);
    check("R10 wrap to 00h", d2, 8'h44);

    // R11: repeated START
    bus_start(); wr_byte(8'h80, ack); wr_byte(8'h1A, ack);
    bus_start(); wr_byte(8'h81, ack); rd_byte(d, 1'b1); bus_stop();
    check("R11 repeated start", d, 8'h02);

    // R11: START mid-byte restarts address phase
    bus_start(); wr_byte(8'h80, ack); send_bit(1'b1); send_bit(1'b0);
    bus_start(); wr_byte(8'h80, ack); wr_byte(8'h13, ack);
    bus_start(); wr_byte(8'h81, ack); rd_byte(d, 1'b1); bus_stop();
    check("R11 start mid byte", d, 8'h28);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule